// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit word in dual-rail form and reports when the word has filled in and when it has drained. Each bit has two rails: one for a zero and one for a one. A bit counts as present when either of its rails is high. When no rail of any bit is high, the word is in its empty (spacer) state.

The block has three outputs. The first is a fill flag, high while every bit is present. The second is an empty flag, high while all 2N rails are low. The third is a hysteresis output that acts like an N-input Muller C-element over the per-bit presence signals. It goes high once the whole word is present. It stays high while the word drains part of the way. It goes low only once every rail has returned to zero.

The design is synchronous. The rails are sampled on the clock edge and every output is a register. The state-holding element is a flip-flop fed back through logic. A sticky flag records any bit whose two rails are both high, which is an illegal code. A downstream stage uses the hysteresis output as its request/acknowledge signal for the next handshake phase.

Top module: `dr_completion_detect`

## Requirements
- R1: A bit counts as present when its zero-rail (`rail0[i]`) or its one-rail (`rail1[i]`) is high; a word that is all zero-rails and a word that is all one-rails are both complete.
- R2: `comp_done` is high in the cycle after an edge at which every bit was present, and low in the cycle after an edge at which any bit was absent.
- R3: `all_empty` is high in the cycle after an edge at which all 2N rails were low, and low after any edge at which any rail was high.
- R4: `done_reset` rises in the same cycle that `comp_done` rises, and never without it.
- R5: Once high, `done_reset` stays high while some, but not all, bits have drained, and across a momentary loss of any single bit.
- R6: `done_reset` falls only in the cycle in which `all_empty` is also high.
- R7: While `done_reset` is low, it stays low while any strict subset of bits is present, whichever bit is last.
- R8: `illegal_err` goes high in the cycle after an edge at which some bit has both rails high. It then stays high until reset, even after the rails return to legal values.
- R9: A synchronous active-high `rst` leaves `comp_done`=0, `all_empty`=1, `done_reset`=0 and `illegal_err`=0 in the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail0 | input | N | Zero-rail of each data bit |
| rail1 | input | N | One-rail of each data bit |
| comp_done | output | 1 | Registered: all bits present |
| all_empty | output | 1 | Registered: all rails low |
| done_reset | output | 1 | Registered C-element output with hysteresis |
| illegal_err | output | 1 | Sticky flag: a bit had both rails high |

## Verification
Every output is a single register stage after the sampled rails. The result of a rail pattern applied between edges is therefore due one cycle later, right after the next rising edge. The bench drives the rails just after a rising edge and samples all four outputs one nanosecond after the following edge. As a result, each check sees exactly the pattern that was presented. The hysteresis checks depend on the previous state, so each scenario builds up to that state one edge at a time before sampling the held value.

// File: rtl/dr_cd_pkg.sv
package dr_cd_pkg;
  // Summary of one sampled word.
  typedef struct packed {
    logic all_valid;   // every bit has a rail asserted
    logic any_active;  // at least one rail asserted
    logic any_clash;   // some bit has both rails asserted
  } word_sum_t;
endpackage

// File: rtl/dr_ack_gen.sv
module dr_ack_gen #(
  parameter int N = 32
) (
  input  logic [N-1:0] rail0,
  input  logic [N-1:0] rail1,
  output logic [N-1:0] ack,
  output logic [N-1:0] clash
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign ack[i]   = rail0[i] | rail1[i];
    assign clash[i] = rail0[i] & rail1[i];
  end
endmodule

// File: rtl/dr_reduce.sv
module dr_reduce
  import dr_cd_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] ack,
  input  logic [N-1:0] clash,
  output word_sum_t    sum
);
  always_comb begin
    sum.all_valid  = &ack;
    sum.any_active = |ack;
    sum.any_clash  = |clash;
  end
endmodule

// File: rtl/dr_hold_elem.sv
module dr_hold_elem (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic keep_i,
  output logic q
);
  // Two-input C-element as a register: set on full, clear on empty, else hold.
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= set_i | (keep_i & q);
  end
endmodule

// File: rtl/dr_completion_detect.sv
module dr_completion_detect
  import dr_cd_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rail0,
  input  logic [N-1:0] rail1,
  output logic         comp_done,
  output logic         all_empty,
  output logic         done_reset,
  output logic         illegal_err
);
  logic [N-1:0] ack;
  logic [N-1:0] clash;
  word_sum_t    sum;

  dr_ack_gen #(.N(N)) u_ack (
    .rail0 (rail0),
    .rail1 (rail1),
    .ack   (ack),
    .clash (clash)
  );

  dr_reduce #(.N(N)) u_red (
    .ack   (ack),
    .clash (clash),
    .sum   (sum)
  );

  dr_hold_elem u_hold (
    .clk    (clk),
    .rst    (rst),
    .set_i  (sum.all_valid),
    .keep_i (sum.any_active),
    .q      (done_reset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      comp_done   <= 1'b0;
      all_empty   <= 1'b1;
      illegal_err <= 1'b0;
    end else begin
      comp_done   <= sum.all_valid;
      all_empty   <= ~sum.any_active;
      illegal_err <= illegal_err | sum.any_clash;
    end
  end
endmodule

// File: rtl/dr_completion_checks.sv
module dr_completion_checks #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] rail0,
  input logic [N-1:0] rail1,
  input logic         comp_done,
  input logic         all_empty,
  input logic         done_reset,
  input logic         illegal_err
);
  p_empty_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (rail0 == '0 && rail1 == '0) |=> all_empty);
  p_done_empty_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(comp_done && all_empty));
  p_rise_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_reset) |-> comp_done);
  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    (!comp_done && !all_empty) |-> $stable(done_reset));
  p_fall_on_empty_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(done_reset) |-> all_empty);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    illegal_err |=> illegal_err);
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!done_reset && !illegal_err && !comp_done && all_empty));
endmodule

bind dr_completion_detect dr_completion_checks #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rail0       (rail0),
  .rail1       (rail1),
  .comp_done   (comp_done),
  .all_empty   (all_empty),
  .done_reset  (done_reset),
  .illegal_err (illegal_err)
);

// File: tb/tb_dr_completion_detect.sv
module tb_dr_completion_detect;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] rail0 = '0;
  logic [N-1:0] rail1 = '0;
  logic comp_done, all_empty, done_reset, illegal_err;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dr_completion_detect #(.N(N)) dut (
    .clk(clk), .rst(rst), .rail0(rail0), .rail1(rail1),
    .comp_done(comp_done), .all_empty(all_empty),
    .done_reset(done_reset), .illegal_err(illegal_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Present a pattern, let one edge capture it, sample just after.
  task automatic step(input logic [N-1:0] z, input logic [N-1:0] o);
    rail0 = z;
    rail1 = o;
    @(posedge clk);
    #1;
  endtask

  // Present bits of mask with data value val.
  task automatic put(input logic [N-1:0] mask, input logic [N-1:0] val);
    step(mask & ~val, mask & val);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step('0, '0);
    rst = 1'b0;
    chk("R9 comp_done", comp_done, 1'b0);
    chk("R9 all_empty", all_empty, 1'b1);
    chk("R9 done_reset", done_reset, 1'b0);
    chk("R9 illegal_err", illegal_err, 1'b0);
  endtask

  task automatic t_one_rail();
    put('1, '0);
    chk("R1 all zero-rails", comp_done, 1'b1);
    put('1, '1);
    chk("R1 all one-rails", comp_done, 1'b1);
    chk("R1 done_reset", done_reset, 1'b1);
    put('0, '0);
    chk("R3 empty", all_empty, 1'b1);
    chk("R6 done_reset low", done_reset, 1'b0);
  endtask

  // Fill all bits except those in last, then last; then drain.
  task automatic t_last(input logic [N-1:0] last, input logic [N-1:0] val);
    logic [N-1:0] early = ~last;
    put(early, val);
    chk("R7 done_reset early", done_reset, 1'b0);
    chk("R2 comp_done early", comp_done, 1'b0);
    chk("R3 not empty", all_empty, 1'b0);
    put('1, val);
    chk("R2 comp_done full", comp_done, 1'b1);
    chk("R4 done_reset rise", done_reset, 1'b1);
    put(last, val);
    chk("R2 comp_done partial", comp_done, 1'b0);
    chk("R5 done_reset held", done_reset, 1'b1);
    put('0, '0);
    chk("R6 done_reset fall", done_reset, 1'b0);
    chk("R3 all_empty", all_empty, 1'b1);
  endtask

  task automatic t_glitch();
    put('1, 32'h5A5A_0F0F);
    put(~32'h0000_0100, 32'h5A5A_0F0F);
    chk("R2 comp_done drop", comp_done, 1'b0);
    chk("R5 done_reset held on drop", done_reset, 1'b1);
    put('1, 32'h5A5A_0F0F);
    chk("R2 comp_done back", comp_done, 1'b1);
    chk("R5 done_reset still", done_reset, 1'b1);
    put('0, '0);
    chk("R6 drained", done_reset, 1'b0);
  endtask

  task automatic t_illegal();
    step(32'h0000_0008, 32'h0000_0008);
    chk("R8 err set", illegal_err, 1'b1);
    step('0, '0);
    chk("R8 err sticky", illegal_err, 1'b1);
    put('1, '0);
    chk("R8 err sticky legal", illegal_err, 1'b1);
    rst = 1'b1;
    step('0, '0);
    rst = 1'b0;
    chk("R9 err cleared", illegal_err, 1'b0);
    chk("R9 done_reset cleared", done_reset, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_one_rail();
    for (int i = 0; i < N; i++) begin
      t_last(N'(1) << i, (i % 2 == 0) ? 32'hA5C3_960F : 32'h3C69_F0A5);
    end
    t_last(32'h8001_0010, 32'h1234_5678);
    t_last(32'h0F00_00F0, 32'hFFFF_0000);
    t_last(32'hFFFF_FFFE, 32'h0000_FFFF);
    t_glitch();
    t_illegal();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule